// File: doc/BRIEF.md
# Short Memory-Reference Execute Unit

This unit executes the 16-bit short memory-reference instructions of a 32-bit processor with sixteen general registers. It accepts one instruction halfword together with that instruction's address. It reads the index register through an external register-file read port and uses that value, with no offset, as the effective address. It then writes the register file, issues a word-wide memory request, redirects the program counter, or updates the four condition flags N, Z, V and C.

Register 0 has a special role. Used as an index, it yields the address of the next instruction. Used as a destination, it discards the result while the flags are still set. This gives test-only and plain-jump forms at no extra cost.

Register-to-register operations finish in one cycle. Loads and stores hold the unit busy until memory answers with a ready strobe. The load-locked and store-conditional operations exchange a request and a success answer with an external reservation monitor during the cycle in which they are accepted.

Top module: `smem_exec`

## Requirements
- R1: An instruction is taken when instr_valid and instr_ready are both high and instr[15:12]=1111 with instr[7]=1. Fields are dst=instr[11:8], x=instr[3:0] and operation instr[6:4]: 7 move, 6 move-with-flags, 5 load, 4 load-with-flags, 3 jump-to-subroutine, 2 store, 1 load-locked, 0 store-conditional. Any other halfword causes no register write, no memory request, no PC load, no reservation signal and no flag change.
- R2: The effective address is r[x] when x is nonzero and instr_pc+2 when x is 0.
- R3: Move and move-with-flags write the effective address to r[dst] through rf_we/rf_waddr/rf_wdata. The write is a single-cycle pulse in the cycle after acceptance.
- R4: The with-flag forms set N=value[31], Z=(value==0), V=0, and C=1 when any of the four bytes of the value is zero. Move, load, jump-to-subroutine and store leave the flags unchanged. The flags are packed {N,Z,V,C}.
- R5: When dst is 0, rf_we stays low, and the flags of the with-flag forms are still updated.
- R6: Jump-to-subroutine writes instr_pc+2 to r[dst] and pulses pc_load with pc_target equal to the effective address, both in the cycle after acceptance. The flags stay unchanged.
- R7: A load raises mem_req with mem_we=0 and mem_addr equal to the effective address with bits 1:0 cleared. It holds mem_req and mem_addr until mem_ready is sampled high. In the next cycle mem_req is low and mem_rdata is written to r[dst].
- R8: A store raises a write request whose mem_wdata is r[dst] sampled at acceptance. It makes no register write and leaves the flags unchanged.
- R9: instr_ready is low from the acceptance of a memory operation until the cycle after mem_ready is sampled. An instruction presented during that time is not taken.
- R10: Load-locked asserts resv_set during its acceptance cycle, with resv_addr equal to the aligned effective address. It then behaves as load-with-flags.
- R11: Store-conditional asserts resv_check during its acceptance cycle. If resv_ok is high, it stores as in R8 and sets V=0. Otherwise it makes no memory request and sets V=1. N, Z and C are cleared in both cases.
- R12: The halfword FFFF rewrites r15 with its own value, with no memory request, PC load or flag change.
- R13: After reset, rf_we, mem_req, pc_load and all flags are 0, and instr_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction halfword present |
| instr | input | 16 | Instruction halfword |
| instr_pc | input | 32 | Address of this instruction |
| instr_ready | output | 1 | Unit can take an instruction |
| rx_idx | output | 4 | Register-file read index for the address register |
| rx_data | input | 32 | Value of r[rx_idx] |
| rd_idx | output | 4 | Register-file read index for the dst register |
| rd_data | input | 32 | Value of r[rd_idx] |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write value |
| pc_load | output | 1 | PC redirect strobe |
| pc_target | output | 32 | New PC value |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the request |
| resv_set | output | 1 | Ask monitor to reserve resv_addr |
| resv_check | output | 1 | Ask monitor whether a conditional store may proceed |
| resv_addr | output | 32 | Address for the monitor |
| resv_ok | input | 1 | Monitor allows the conditional store |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow / conditional-store failure flag |
| flag_c | output | 1 | Carry / zero-byte flag |

## Verification
In a jump-to-subroutine, the register write of the return address and the read of the jump target fall in the same cycle. When dst equals x they hit the same register, and when x is 0 both derive from the instruction address. The bench sweeps every dst/x pair of this operation. It judges that pc_target carries the register's old value or instr_pc+2, while rf_wdata carries instr_pc+2. The same sweep over move-with-flags pairs a discarded write to register 0 with a flag update that must still occur.

// File: rtl/smem_exec.sv
module smem_exec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [15:0] instr,
  input  logic [31:0] instr_pc,
  output logic        instr_ready,
  output logic [3:0]  rx_idx,
  input  logic [31:0] rx_data,
  output logic [3:0]  rd_idx,
  input  logic [31:0] rd_data,
  output logic        rf_we,
  output logic [3:0]  rf_waddr,
  output logic [31:0] rf_wdata,
  output logic        pc_load,
  output logic [31:0] pc_target,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  output logic        resv_set,
  output logic        resv_check,
  output logic [31:0] resv_addr,
  input  logic        resv_ok,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c
);
  localparam logic [2:0] OP_MOV   = 3'd7;
  localparam logic [2:0] OP_MOVF  = 3'd6;
  localparam logic [2:0] OP_LD    = 3'd5;
  localparam logic [2:0] OP_LDF   = 3'd4;
  localparam logic [2:0] OP_JSR   = 3'd3;
  localparam logic [2:0] OP_ST    = 3'd2;
  localparam logic [2:0] OP_LDLK  = 3'd1;
  localparam logic [2:0] OP_STC   = 3'd0;

  logic [3:0]  cc;
  logic [2:0]  op_q;
  logic [3:0]  dst_q;

  wire [3:0]  dst     = instr[11:8];
  wire [3:0]  xr      = instr[3:0];
  wire [2:0]  op      = instr[6:4];
  wire        in_grp  = (instr[15:12] == 4'hF) && instr[7];
  wire        go      = instr_valid && !mem_req && in_grp;
  wire [31:0] next_pc = instr_pc + 32'd2;
  wire [31:0] ea      = (xr == 4'd0) ? next_pc : rx_data;
  wire [31:0] ea_word = {ea[31:2], 2'b00};
  wire        done    = mem_req && mem_ready;

  function automatic logic [3:0] cc_of(input logic [31:0] v);
    logic zb;
    zb = (v[7:0] == 8'd0) || (v[15:8] == 8'd0) || (v[23:16] == 8'd0) || (v[31:24] == 8'd0);
    return {v[31], v == 32'd0, 1'b0, zb};
  endfunction

  assign instr_ready = !mem_req;
  assign rx_idx      = xr;
  assign rd_idx      = dst;
  assign resv_set    = go && (op == OP_LDLK);
  assign resv_check  = go && (op == OP_STC);
  assign resv_addr   = ea_word;
  assign {flag_n, flag_z, flag_v, flag_c} = cc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc        <= 4'd0;
      rf_we     <= 1'b0;
      rf_waddr  <= 4'd0;
      rf_wdata  <= 32'd0;
      pc_load   <= 1'b0;
      pc_target <= 32'd0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= 32'd0;
      mem_wdata <= 32'd0;
      op_q      <= 3'd0;
      dst_q     <= 4'd0;
    end else begin
      rf_we   <= 1'b0;
      pc_load <= 1'b0;
      if (go) begin
        op_q  <= op;
        dst_q <= dst;
        case (op)
          OP_MOV, OP_MOVF: begin
            rf_we    <= dst != 4'd0;
            rf_waddr <= dst;
            rf_wdata <= ea;
            if (op == OP_MOVF) cc <= cc_of(ea);
          end
          OP_JSR: begin
            rf_we     <= dst != 4'd0;
            rf_waddr  <= dst;
            rf_wdata  <= next_pc;
            pc_load   <= 1'b1;
            pc_target <= ea;
          end
          OP_LD, OP_LDF, OP_LDLK: begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ea_word;
          end
          OP_ST: begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ea_word;
            mem_wdata <= rd_data;
          end
          default: begin
            cc <= {2'b00, !resv_ok, 1'b0};
            if (resv_ok) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= ea_word;
              mem_wdata <= rd_data;
            end
          end
        endcase
      end else if (done) begin
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
        if (!mem_we) begin
          rf_we    <= dst_q != 4'd0;
          rf_waddr <= dst_q;
          rf_wdata <= mem_rdata;
          if (op_q != OP_LD) cc <= cc_of(mem_rdata);
        end
      end
    end
  end

  p_no_r0_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != 4'd0);
  p_jump_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $stable(cc));
  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> !mem_req && instr_ready);
  p_lock_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resv_set |=> mem_req && !mem_we);
  p_cond_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resv_check && !resv_ok |=> !mem_req && cc == 4'b0010);
endmodule

// File: tb/tb_smem_exec.sv
module tb_smem_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = 16'd0;
  logic [31:0] instr_pc = 32'd0;
  logic        instr_ready;
  logic [3:0]  rx_idx, rd_idx, rf_waddr;
  logic [31:0] rx_data, rd_data, rf_wdata, pc_target, mem_addr, mem_wdata, resv_addr;
  logic        rf_we, pc_load, mem_req, mem_we, resv_set, resv_check;
  logic [31:0] mem_rdata = 32'd0;
  logic        mem_ready = 1'b0;
  logic        resv_ok = 1'b0;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic [31:0] regs [16];
  logic [3:0]  ef;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign rx_data = regs[rx_idx];
  assign rd_data = regs[rd_idx];

  smem_exec dut (.*);

  wire [3:0] fl = {flag_n, flag_z, flag_v, flag_c};

  function automatic logic [3:0] ccx(input logic [31:0] v);
    logic zb;
    zb = 1'b0;
    for (int b = 0; b < 4; b++) if (((v >> (8*b)) & 32'hFF) == 0) zb = 1'b1;
    return {v[31], v == 32'd0, 1'b0, zb};
  endfunction

  function automatic logic [31:0] mdat(input logic [31:0] a);
    return a[4] ? {~a[15:8], a[7:0], 8'h00, a[23:16]} : (a * 32'd3) ^ 32'h8000_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic present(input logic [15:0] ins, input logic [31:0] pc);
    @(negedge clk);
    instr = ins; instr_pc = pc; instr_valid = 1'b1;
    #1;
  endtask

  task automatic accept_edge();
    @(posedge clk); #1;
    instr_valid = 1'b0;
  endtask

  task automatic run_mem(input logic [3:0] d, input logic [31:0] addr, input int lat,
                         input bit is_wr, input logic [31:0] wd, input int fmode);
    logic [31:0] rd;
    chk(mem_req && mem_we == is_wr, "R7 request raised", {30'd0, mem_req, mem_we}, {30'd0, 1'b1, is_wr});
    chk(mem_addr == addr, "R7 aligned address", mem_addr, addr);
    if (is_wr) chk(mem_wdata == wd, "R8 store data", mem_wdata, wd);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      instr = 16'hF1F2; instr_valid = 1'b1; mem_ready = 1'b0;
      @(posedge clk); #1;
      chk(mem_req && !instr_ready && mem_addr == addr && !rf_we, "R9 stall holds", mem_addr, addr);
    end
    @(negedge clk);
    instr_valid = 1'b0; mem_ready = 1'b1; rd = mdat(addr); mem_rdata = rd;
    @(posedge clk); #1;
    mem_ready = 1'b0;
    chk(!mem_req && instr_ready, "R9 release", {31'd0, mem_req}, 32'd0);
    if (is_wr) begin
      chk(!rf_we, "R8 no register write", {31'd0, rf_we}, 32'd0);
    end else begin
      chk(rf_we == (d != 0), "R7 load write strobe", {31'd0, rf_we}, {31'd0, d != 0});
      if (d != 0) chk(rf_waddr == d && rf_wdata == rd, "R7 load data", rf_wdata, rd);
      if (fmode == 1) ef = ccx(rd);
    end
    chk(fl == ef, "R4 flags after memory op", {28'd0, fl}, {28'd0, ef});
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = (i * 32'h9E37_79B9) ^ (i << 27);
    regs[0] = 32'hDEAD_BEEF;
    regs[5] = 32'd0;
    regs[6] = 32'h1200_3456;
    regs[9] = 32'h8000_0001;
    ef = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    chk(!rf_we && !mem_req && !pc_load && fl == 0 && instr_ready, "R13 reset state",
        {27'd0, rf_we, mem_req, pc_load, instr_ready, 1'b0}, 32'h2);
    rst_n = 1'b1;

    // R3 R4 R5 R2: move and move-with-flags over every dst/x pair
    for (int op = 6; op <= 7; op++)
      for (int d = 0; d < 16; d++)
        for (int x = 0; x < 16; x++) begin
          logic [31:0] pc, ea;
          pc = (d == 3) ? 32'hFFFF_FFF0 : 32'h0000_1000 + (d * 16 + x) * 4;
          ea = (x == 0) ? pc + 2 : regs[x];
          present({4'hF, d[3:0], 1'b1, op[2:0], x[3:0]}, pc);
          accept_edge();
          chk(rf_we == (d != 0), "R5 dst zero discards", {31'd0, rf_we}, {31'd0, d != 0});
          if (d != 0) chk(rf_waddr == d && rf_wdata == ea, "R3 move value R2 ea", rf_wdata, ea);
          if (op == 6) ef = ccx(ea);
          chk(fl == ef, "R4 move flags", {28'd0, fl}, {28'd0, ef});
          @(posedge clk); #1;
          chk(!rf_we && !mem_req && !pc_load, "R3 single pulse", {31'd0, rf_we}, 32'd0);
        end

    // R1: out-of-group halfwords are ignored
    ef = fl;
    for (int h = 0; h < 16; h++)
      for (int b7 = 0; b7 < 2; b7++) begin
        if (h == 15 && b7 == 1) continue;
        present({h[3:0], 4'h3, b7[0], h[2:0], 4'h2}, 32'h200);
        chk(!resv_set && !resv_check, "R1 ignored no monitor", {30'd0, resv_set, resv_check}, 32'd0);
        accept_edge();
        chk(!rf_we && !mem_req && !pc_load && instr_ready && fl == ef, "R1 ignored",
            {26'd0, fl, rf_we, mem_req}, {26'd0, ef, 2'b00});
      end

    // R6: jump-to-subroutine every dst/x pair
    for (int d = 0; d < 16; d++)
      for (int x = 0; x < 16; x++) begin
        logic [31:0] pc, ea;
        pc = 32'h0004_0000 + (d * 16 + x) * 2;
        ea = (x == 0) ? pc + 2 : regs[x];
        present({4'hF, d[3:0], 1'b1, 3'd3, x[3:0]}, pc);
        accept_edge();
        chk(pc_load && pc_target == ea, "R6 jump target", pc_target, ea);
        chk(rf_we == (d != 0), "R6 link strobe", {31'd0, rf_we}, {31'd0, d != 0});
        if (d != 0) chk(rf_waddr == d && rf_wdata == pc + 2, "R6 link value", rf_wdata, pc + 2);
        chk(fl == ef, "R6 flags kept", {28'd0, fl}, {28'd0, ef});
      end

    // R7 R10 R4: loads with varying latency
    for (int x = 0; x < 16; x++)
      for (int k = 0; k < 3; k++) begin
        logic [2:0] op;
        logic [3:0] d;
        logic [31:0] pc, ea;
        op = (k == 0) ? 3'd5 : (k == 1) ? 3'd4 : 3'd1;
        d = 4'((x * 7 + k) % 16);
        pc = 32'h0000_3000 + x * 8;
        ea = (x == 0) ? pc + 2 : regs[x];
        present({4'hF, d, 1'b1, op, x[3:0]}, pc);
        if (op == 3'd1) chk(resv_set && resv_addr == {ea[31:2], 2'b00}, "R10 reserve request", resv_addr, {ea[31:2], 2'b00});
        else chk(!resv_set, "R10 no reserve", {31'd0, resv_set}, 32'd0);
        accept_edge();
        run_mem(d, {ea[31:2], 2'b00}, (x + k) % 4, 1'b0, 32'd0, (op == 3'd5) ? 0 : 1);
      end

    // R8: stores
    for (int x = 0; x < 16; x++) begin
      logic [3:0] d;
      logic [31:0] pc, ea;
      d = 4'((x * 5 + 1) % 16);
      pc = 32'h0000_5000 + x * 4;
      ea = (x == 0) ? pc + 2 : regs[x];
      present({4'hF, d, 1'b1, 3'd2, x[3:0]}, pc);
      accept_edge();
      run_mem(d, {ea[31:2], 2'b00}, x % 3, 1'b1, regs[d], 0);
    end

    // R11: store-conditional success and failure
    for (int x = 0; x < 16; x++) begin
      logic [3:0] d;
      logic [31:0] ea;
      d = 4'((x * 3) % 16);
      ea = (x == 0) ? 32'h0000_6002 : regs[x];
      resv_ok = x[0];
      present({4'hF, d, 1'b1, 3'd0, x[3:0]}, 32'h0000_6000);
      chk(resv_check && resv_addr == {ea[31:2], 2'b00}, "R11 check request", resv_addr, {ea[31:2], 2'b00});
      accept_edge();
      ef = resv_ok ? 4'b0000 : 4'b0010;
      if (resv_ok) run_mem(d, {ea[31:2], 2'b00}, 1, 1'b1, regs[d], 0);
      else chk(!mem_req && instr_ready && fl == ef, "R11 failure", {28'd0, fl}, {28'd0, ef});
    end
    resv_ok = 1'b0;

    // R12: all-ones halfword
    ef = fl;
    present(16'hFFFF, 32'h0000_7000);
    accept_edge();
    chk(rf_we && rf_waddr == 4'd15 && rf_wdata == regs[15], "R12 FFFF rewrites r15", rf_wdata, regs[15]);
    chk(!mem_req && !pc_load && fl == ef, "R12 FFFF no side effect", {28'd0, fl}, {28'd0, ef});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule